// File: doc/BRIEF.md
# Floating-Point Adder/Subtractor with Two's-Complement Exponent

This block adds or subtracts two 32-bit floating-point words and returns one result word and a special-value flag. The word format follows the usual sign, exponent, fraction split, but the exponent is stored as a plain two's-complement number with no bias. Because the exponent needs no bias correction, the exponent compare, the alignment shift and the normalization step all work directly on signed values.

The datapath unpacks both operands and gives each its hidden bit unless its exponent is the most negative code. It orders the operands by magnitude and shifts the smaller one right by the exponent difference, dropping the bits that fall off. It then adds the two mantissas, or negates the smaller one and adds when the effective signs differ. A carry out moves the exponent up by one. Otherwise a leading-zero count drives a left shift, and that shift stops at the exponent floor. If either operand has the largest exponent code, the result is a fixed special word.

The datapath is combinational from the operand ports to a single output register, so the result appears one clock after the operands are presented. A new operation can start on every cycle.

Top module: `fp_addsub_tc`

## Requirements
- R1: Word layout: bit 31 is the sign, bits 30:23 are the exponent in two's complement, and bits 22:0 are the fraction. For an exponent e from -127 to 126 the magnitude is (1 + frac/2^23)·2^e. The exponent code 0x80 (-128) has no hidden bit and means (frac/2^23)·2^-127.
- R2: With `sub_sel`=0 the result is A+B. With `sub_sel`=1 it is A−B, which the block computes as A plus B with its sign bit inverted.
- R3: The operand of smaller magnitude is shifted right by the difference of the effective exponents, and the bits shifted out are dropped. A difference of 24 or more makes that operand contribute zero.
- R4: If the 24-bit mantissa sum carries out, it is shifted right by one (its lowest bit is dropped) and the exponent goes up by one.
- R5: Otherwise the sum is shifted left until bit 23 is set, and the exponent goes down by the shift count.
- R6: The left shift never takes the exponent below -127. A sum that still lacks bit 23 at that floor is written out with exponent code 0x80.
- R7: An exact zero sum gives the word 0x40000000 (sign 0, exponent code 0x80, fraction 0), whatever the operand signs.
- R8: If either operand has exponent code 0x7F, the result is 0x3F800000 and `special`=1. Otherwise `special`=0, except in the case of R9.
- R9: If a carry (R4) would raise the exponent to 127, the result is 0x3F800000 and `special`=1.
- R10: The sign of a non-zero result is the sign of the operand with the larger magnitude, taking B with its sign inverted under subtraction.
- R11: `result` and `special` are registered and show the operation presented one rising edge earlier. A synchronous reset sets them to 0x40000000 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| result | output | 32 | Registered result word |
| special | output | 1 | Registered special/overflow flag |

## Verification
Directed pairs each target one path and have a known answer: equal exponents that carry, exact cancellation, near-cancellation that needs a long left shift, a gap of 24 or more that drops the small operand, operands at the exponent floor, a carry into the top exponent, and inputs with the special code. Random pairs with nearby exponents and matching upper fraction bits stress the leading-zero normalization and the choice of result sign. Fully random pairs cover the far-alignment and special paths. A wrong truncation point, a missing floor clamp or a swapped sign each changes the bit pattern that the reference function predicts.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpas_op_e;

  localparam int DEF_EXP_W  = 8;
  localparam int DEF_FRAC_W = 23;
endpackage

// File: rtl/fpas_shift.sv
// Logarithmic barrel shifter; LEFT selects the direction.
module fpas_shift #(
  parameter int W    = 24,
  parameter int SHW  = 5,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    if (LEFT) begin : g_left
      assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
    end else begin : g_right
      assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
    end
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/fpas_lzc.sv
// Leading-zero counter; returns W for an all-zero input.
module fpas_lzc #(
  parameter int W  = 24,
  parameter int CW = 5
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpas_unpack.sv
// Splits a word into sign, effective exponent, mantissa with hidden bit.
module fpas_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0]       word,
  output logic                        sign,
  output logic signed [EXP_W+1:0]     eff_exp,
  output logic [FRAC_W:0]             mant,
  output logic                        is_max
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int XW     = EXP_W + 2;
  localparam int EMIN   = -(1 << (EXP_W - 1));

  logic [EXP_W-1:0] efield;
  logic             is_min;

  assign sign   = word[WORD_W-1];
  assign efield = word[WORD_W-2 -: EXP_W];
  assign is_min = (efield == {1'b1, {(EXP_W-1){1'b0}}});
  assign is_max = (efield == {1'b0, {(EXP_W-1){1'b1}}});

  assign eff_exp = is_min ? XW'(EMIN + 1) : {{2{efield[EXP_W-1]}}, efield};
  assign mant    = {~is_min, word[FRAC_W-1:0]};
endmodule

// File: rtl/fpas_align.sv
// Orders operands by magnitude and right-aligns the smaller mantissa.
module fpas_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    sign_a,
  input  logic signed [EXP_W+1:0] exp_a,
  input  logic [FRAC_W:0]         mant_a,
  input  logic                    sign_b,
  input  logic signed [EXP_W+1:0] exp_b,
  input  logic [FRAC_W:0]         mant_b,
  output logic                    big_sign,
  output logic signed [EXP_W+1:0] big_exp,
  output logic [FRAC_W:0]         big_mant,
  output logic [FRAC_W:0]         small_al,
  output logic                    eff_sub
);
  localparam int XW     = EXP_W + 2;
  localparam int MANT_W = FRAC_W + 1;
  localparam int SHW    = $clog2(MANT_W + 1);

  logic                 a_big;
  logic signed [XW-1:0] small_exp;
  logic signed [XW-1:0] dexp;
  logic [MANT_W-1:0]    small_mant;
  logic [MANT_W-1:0]    shifted;
  logic                 far;

  assign a_big = (exp_a > exp_b) || ((exp_a == exp_b) && (mant_a >= mant_b));

  assign big_sign   = a_big ? sign_a : sign_b;
  assign big_exp    = a_big ? exp_a  : exp_b;
  assign big_mant   = a_big ? mant_a : mant_b;
  assign small_exp  = a_big ? exp_b  : exp_a;
  assign small_mant = a_big ? mant_b : mant_a;
  assign eff_sub    = sign_a ^ sign_b;

  assign dexp = big_exp - small_exp;
  assign far  = ($unsigned(dexp) >= XW'(MANT_W));

  fpas_shift #(.W(MANT_W), .SHW(SHW), .LEFT(1'b0)) u_rsh (
    .din  (small_mant),
    .amt  (dexp[SHW-1:0]),
    .dout (shifted)
  );

  assign small_al = far ? '0 : shifted;
endmodule

// File: rtl/fpas_norm.sv
// Signed mantissa add, carry renormalization, clamped left normalization, pack.
module fpas_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    big_sign,
  input  logic signed [EXP_W+1:0] big_exp,
  input  logic [FRAC_W:0]         big_mant,
  input  logic [FRAC_W:0]         small_al,
  input  logic                    eff_sub,
  output logic [EXP_W+FRAC_W:0]   word,
  output logic                    ovf
);
  localparam int XW     = EXP_W + 2;
  localparam int MANT_W = FRAC_W + 1;
  localparam int SHW    = $clog2(MANT_W + 1);
  localparam int EMIN   = -(1 << (EXP_W - 1));
  localparam int EMAX   = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] MIN_CODE = {1'b1, {(EXP_W-1){1'b0}}};

  logic [MANT_W:0]      addend;
  logic [MANT_W:0]      sum;
  logic                 carry;
  logic [SHW-1:0]       lz;
  logic signed [XW-1:0] room;
  logic [SHW-1:0]       sh;
  logic [MANT_W-1:0]    nmant;
  logic signed [XW-1:0] exp_up;
  logic signed [XW-1:0] exp_dn;

  // Negate the smaller mantissa for an effective subtraction.
  assign addend = eff_sub ? (~{1'b0, small_al} + 1'b1) : {1'b0, small_al};
  assign sum    = {1'b0, big_mant} + addend;
  assign carry  = sum[MANT_W];

  fpas_lzc #(.W(MANT_W), .CW(SHW)) u_lzc (
    .din   (sum[MANT_W-1:0]),
    .count (lz)
  );

  // Headroom above the exponent floor limits the normalizing shift.
  assign room = big_exp - XW'(EMIN + 1);
  assign sh   = ($unsigned(room) < XW'(lz)) ? room[SHW-1:0] : lz;

  fpas_shift #(.W(MANT_W), .SHW(SHW), .LEFT(1'b1)) u_lsh (
    .din  (sum[MANT_W-1:0]),
    .amt  (sh),
    .dout (nmant)
  );

  assign exp_up = big_exp + XW'(1);
  assign exp_dn = big_exp - {{(XW-SHW){1'b0}}, sh};
  assign ovf    = carry && (exp_up == XW'(EMAX));

  always_comb begin
    if (carry) begin
      word = {big_sign, exp_up[EXP_W-1:0], sum[FRAC_W:1]};
    end else if (sum == '0) begin
      word = {1'b0, MIN_CODE, {FRAC_W{1'b0}}};
    end else if (nmant[MANT_W-1]) begin
      word = {big_sign, exp_dn[EXP_W-1:0], nmant[FRAC_W-1:0]};
    end else begin
      word = {big_sign, MIN_CODE, nmant[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fp_addsub_tc.sv
module fp_addsub_tc
  import fpas_pkg::*;
#(
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [EXP_W+FRAC_W:0]     op_a,
  input  logic [EXP_W+FRAC_W:0]     op_b,
  input  logic                      sub_sel,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      special
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int XW     = EXP_W + 2;
  localparam logic [WORD_W-1:0] ZERO_WORD =
    {1'b0, 1'b1, {(EXP_W-1){1'b0}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] SPEC_WORD =
    {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

  fpas_op_e             op;
  logic                 sa, sb_raw, sb;
  logic signed [XW-1:0] ea, eb;
  logic [FRAC_W:0]      ma, mb;
  logic                 max_a, max_b;
  logic                 big_sign, eff_sub, ovf;
  logic signed [XW-1:0] big_exp;
  logic [FRAC_W:0]      big_mant, small_al;
  logic [WORD_W-1:0]    sum_word;
  logic [WORD_W-1:0]    nxt_word;
  logic                 nxt_spec;

  assign op = fpas_op_e'(sub_sel);

  fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word (op_a), .sign (sa), .eff_exp (ea), .mant (ma), .is_max (max_a)
  );

  fpas_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word (op_b), .sign (sb_raw), .eff_exp (eb), .mant (mb), .is_max (max_b)
  );

  assign sb = sb_raw ^ (op == OP_SUB);

  fpas_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sign_a   (sa),
    .exp_a    (ea),
    .mant_a   (ma),
    .sign_b   (sb),
    .exp_b    (eb),
    .mant_b   (mb),
    .big_sign (big_sign),
    .big_exp  (big_exp),
    .big_mant (big_mant),
    .small_al (small_al),
    .eff_sub  (eff_sub)
  );

  fpas_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .big_sign (big_sign),
    .big_exp  (big_exp),
    .big_mant (big_mant),
    .small_al (small_al),
    .eff_sub  (eff_sub),
    .word     (sum_word),
    .ovf      (ovf)
  );

  assign nxt_spec = max_a | max_b | ovf;
  assign nxt_word = nxt_spec ? SPEC_WORD : sum_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= ZERO_WORD;
      special <= 1'b0;
    end else begin
      result  <= nxt_word;
      special <= nxt_spec;
    end
  end
endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  sub_sel,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  special
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] MAX_CODE = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] MIN_CODE = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] ZERO_WORD = {1'b0, MIN_CODE, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] NZERO_WORD = {1'b1, MIN_CODE, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] SPEC_WORD = {1'b0, MAX_CODE, {FRAC_W{1'b0}}};

  logic a_max, b_max, r_max, r_zero_mag;
  assign a_max      = (op_a[WORD_W-2 -: EXP_W] == MAX_CODE);
  assign b_max      = (op_b[WORD_W-2 -: EXP_W] == MAX_CODE);
  assign r_max      = (result[WORD_W-2 -: EXP_W] == MAX_CODE);
  assign r_zero_mag = (result[WORD_W-2:0] == ZERO_WORD[WORD_W-2:0]);

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (result == ZERO_WORD) && !special);

  assert_special_input_R8: assert property (@(posedge clk) disable iff (rst)
    (a_max || b_max) |=> special && (result == SPEC_WORD));

  assert_flag_matches_code_R9: assert property (@(posedge clk) disable iff (rst)
    special == r_max);

  assert_zero_positive_R7: assert property (@(posedge clk) disable iff (rst)
    r_zero_mag |-> !result[WORD_W-1]);

  assert_self_cancel_R2: assert property (@(posedge clk) disable iff (rst)
    (sub_sel && (op_a == op_b) && !a_max) |=> (result == ZERO_WORD) && !special);

  assert_add_zero_identity_R3: assert property (@(posedge clk) disable iff (rst)
    (!sub_sel && (op_b == ZERO_WORD) && !a_max && (op_a != NZERO_WORD))
      |=> (result == $past(op_a)) && !special);
endmodule

bind fp_addsub_tc fpas_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpas_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .sub_sel (sub_sel),
  .result  (result),
  .special (special)
);

// File: tb/tb_fp_addsub_tc.sv
module tb_fp_addsub_tc;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        sub_sel = 1'b0;
  logic [31:0] result;
  logic        special;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_addsub_tc dut (
    .clk (clk), .rst (rst), .op_a (op_a), .op_b (op_b),
    .sub_sel (sub_sel), .result (result), .special (special)
  );

  // Reference built from the requirements: {special, word}.
  function automatic logic [32:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
                                           input logic s);
    int     xa, xb, ea, eb, eg, es, d, e;
    longint ma, mb, mg, ms, sum;
    logic   sa, sb, sg, a_first;
    xa = int'($signed(a[30:23]));
    xb = int'($signed(b[30:23]));
    if (xa == 127 || xb == 127) return {1'b1, 32'h3F800000};       // R8
    ea = (xa == -128) ? -127 : xa;                                  // R1
    eb = (xb == -128) ? -127 : xb;
    ma = (xa == -128) ? longint'(a[22:0]) : (longint'(1) << 23) + longint'(a[22:0]);
    mb = (xb == -128) ? longint'(b[22:0]) : (longint'(1) << 23) + longint'(b[22:0]);
    sa = a[31];
    sb = b[31] ^ s;                                                 // R2
    a_first = (ea > eb) || (ea == eb && ma >= mb);
    eg = a_first ? ea : eb;  es = a_first ? eb : ea;
    mg = a_first ? ma : mb;  ms = a_first ? mb : ma;
    sg = a_first ? sa : sb;                                         // R10
    d  = eg - es;
    ms = (d >= 24) ? 0 : (ms >> d);                                 // R3
    sum = (sa == sb) ? (mg + ms) : (mg - ms);
    if (sum == 0) return {1'b0, 32'h40000000};                      // R7
    e = eg;
    if (sum >= (longint'(1) << 24)) begin                           // R4
      sum = sum >> 1;
      e   = e + 1;
      if (e == 127) return {1'b1, 32'h3F800000};                    // R9
    end else begin
      while (sum < (longint'(1) << 23) && e > -127) begin           // R5, R6
        sum = sum << 1;
        e   = e - 1;
      end
      if (sum < (longint'(1) << 23)) e = -128;
    end
    return {1'b0, sg, 8'(e), 23'(sum)};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_w, input logic exp_s);
    checks++;
    if (result !== exp_w || special !== exp_s) begin
      failures++;
      $display("FAIL %s: got result=%h special=%b expected result=%h special=%b",
               tag, result, special, exp_w, exp_s);
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register).
  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic s, input logic [31:0] exp_w, input logic exp_s);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = s;
    @(negedge clk);
    check(tag, exp_w, exp_s);
  endtask

  task automatic run_ref(input string tag, input logic [31:0] a, input logic [31:0] b,
                         input logic s);
    logic [32:0] r;
    r = ref_calc(a, b, s);
    run_op(tag, a, b, s, r[31:0], r[32]);
  endtask

  function automatic logic [31:0] near_word(input logic [31:0] base, input int span);
    logic [7:0] ex;
    logic [31:0] w;
    w  = $urandom();
    ex = base[30:23] + 8'($urandom_range(0, span)) - 8'(span / 2);
    w[30:23] = ex;
    if ($urandom_range(0, 1) == 1) w[22:12] = base[22:12];
    return w;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check("R11 reset state", 32'h40000000, 1'b0);
    rst = 1'b0;

    run_op("R4 1.0+1.0 carry",             32'h00000000, 32'h00000000, 1'b0, 32'h00800000, 1'b0);
    run_op("R7 1.0-1.0 exact zero",        32'h00000000, 32'h00000000, 1'b1, 32'h40000000, 1'b0);
    run_op("R7 -1.0+1.0 positive zero",    32'h80000000, 32'h00000000, 1'b0, 32'h40000000, 1'b0);
    run_op("R3 1.0+2^-30 dropped",         32'h00000000, 32'h71000000, 1'b0, 32'h00000000, 1'b0);
    run_op("R5 1.5-1.0 normalize",         32'h00400000, 32'h00000000, 1'b1, 32'h7F800000, 1'b0);
    run_op("R10 1.0-1.5 negative",         32'h00000000, 32'h00400000, 1'b1, 32'hFF800000, 1'b0);
    run_op("R2 1.0 minus -1.0",            32'h00000000, 32'h80000000, 1'b1, 32'h00800000, 1'b0);
    run_op("R8 special operand A",         32'h3F812345, 32'h00000000, 1'b0, 32'h3F800000, 1'b1);
    run_op("R8 special operand B",         32'h00000000, 32'hBFFFFFFF, 1'b1, 32'h3F800000, 1'b1);
    run_op("R9 overflow to top exponent",  32'h3F400000, 32'h3F400000, 1'b0, 32'h3F800000, 1'b1);
    run_op("R6 floor stays unnormalized",  32'h40800000, 32'h40400000, 1'b1, 32'h40400000, 1'b0);
    run_op("R1 floor codes sum to normal", 32'h40400000, 32'h40400000, 1'b0, 32'h40800000, 1'b0);
    run_op("R3 gap of 24 dropped",         32'h00000000, 32'h74000000, 1'b0, 32'h00000000, 1'b0);
    run_op("R3 gap of 23 truncated",       32'h00000000, 32'h74800000, 1'b0, 32'h00000001, 1'b0);
    run_ref("R5 long cancel",              32'h00000001, 32'h00000000, 1'b1);
    run_ref("R6 floor clamp from -126",    32'h41000001, 32'h41000000, 1'b1);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] a, b;
      logic        s;
      a = $urandom();
      s = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 3))
        0: b = $urandom();
        1: b = near_word(a, 4);
        2: begin a[30:23] = 8'($urandom_range(0, 3)) + 8'h7E; b = near_word(a, 6); end
        default: begin b = near_word(a, 50); end
      endcase
      run_ref("R2 R3 R4 R5 R6 R10 random", a, b, s);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule